// File: doc/BRIEF.md
# Prefix-OR Priority Encoder

This block picks one winner out of a vector of request lines and reports the position of that winner as a binary number. Position 0 has the highest priority and the top position the lowest, so when several lines are raised together the one with the smallest index is reported. A separate flag says whether any line was raised at all. The block has no state and no clock: the result follows the request vector combinationally.

The winner is found without a serial scan. A parallel-prefix OR network with shift distances 1, 2, 4 and so on spreads every raised bit towards the most significant end. That network takes ceil(log2(N)) OR levels and yields a thermometer pattern that starts at the winning bit. The single rising edge of that pattern is isolated as a one-hot word, and each bit of the one-hot word is OR-folded into the index bits. The block is intended as the fast leaf cell inside wider encoders.

Top module: `prefix_prio_enc`

## Requirements
- R1: When at least one request bit is set, `idx_o` equals the lowest index i for which `req_i[i]` is 1.
- R2: `valid_o` is 1 exactly when at least one bit of `req_i` is 1.
- R3: With `req_i` all zero, `idx_o` is 0 and `valid_o` is 0.
- R4: With only `req_i[0]` set, `idx_o` is 0 and `valid_o` is 1, so a grant of line 0 is told apart from no request by `valid_o` alone.
- R5: `idx_o` is ceil(log2(WIDTH)) bits wide and never carries a value of WIDTH or more, also for a WIDTH that is not a power of two.
- R6: With only the top bit `req_i[WIDTH-1]` set, `idx_o` equals WIDTH-1.
- R7: Bits of `req_i` above the winning bit have no effect: with a fixed lowest set bit k, any pattern in bits k+1 and upward yields `idx_o` equal to k.
- R8: The outputs are a combinational function of `req_i`; a new request vector is reflected on `idx_o` and `valid_o` within the same clock period, with no clock or register involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_i | input | WIDTH | Request lines; bit 0 has the highest priority |
| idx_o | output | ceil(log2(WIDTH)) | Binary index of the winning request line, 0 when none |
| valid_o | output | 1 | 1 when any request line is raised |

## Verification
The hardest case to reach from the ports is a dense vector whose winner sits high up, because uniformly random vectors almost always have a set bit among the lowest few positions and so rarely exercise the long prefix spans. The stimulus therefore fixes a chosen lowest set bit k, clears everything below it and fills everything above it with random bits, sweeping k across the full width. Sparse vectors are made by ANDing several random words, and every single-bit vector and the all-zero vector are also applied. The default width of 24 is not a power of two, so the unused index codes at 24 and above are also checked.

// File: rtl/prio_pkg.sv
package prio_pkg;

    // Index width for a request vector of n lines (at least one bit).
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Number of doubling levels needed so a spread covers n lines.
    function automatic int span_levels(input int n);
        return (n > 1) ? $clog2(n) : 0;
    endfunction

endpackage

// File: rtl/prefix_or_net.sv
module prefix_or_net
    import prio_pkg::*;
#(
    parameter int WIDTH = 24
) (
    input  logic [WIDTH-1:0] req_i,
    output logic [WIDTH-1:0] therm_o
);
    localparam int LVLS = span_levels(WIDTH);

    logic [WIDTH-1:0] span_d;

    // Doubling-span OR: after level l every bit sees 2^(l+1) lines below it.
    always_comb begin
        span_d = req_i;
        for (int l = 0; l < LVLS; l++) begin
            span_d = span_d | (span_d << (1 << l));
        end
    end

    assign therm_o = span_d;

    // R1: the pattern is monotone, once set it stays set towards the MSB
    always_comb begin
        if (!$isunknown(req_i)) begin
            for (int i = 0; i + 1 < WIDTH; i++) begin
                a_r1_therm_monotone: assert (!therm_o[i] || therm_o[i+1])
                    else $error("thermometer broken at bit %0d", i);
            end
            // R1: every request bit is covered by the spread
            a_r1_covers_req: assert ((req_i & ~therm_o) == '0)
                else $error("request bit lost in prefix spread");
        end
    end

endmodule

// File: rtl/edge_pick.sv
module edge_pick #(
    parameter int WIDTH = 24
) (
    input  logic [WIDTH-1:0] therm_i,
    output logic [WIDTH-1:0] hot_o
);
    logic [WIDTH-1:0] below_q;

    // A bit is the edge when it is set and the bit under it is clear.
    assign below_q = therm_i << 1;
    assign hot_o   = therm_i & ~below_q;

    // R1: at most one winner is ever picked, and one exists for any set input
    always_comb begin
        if (!$isunknown(therm_i)) begin
            a_r1_single_winner: assert ($onehot0(hot_o))
                else $error("more than one edge picked");
            a_r2_winner_exists: assert ((therm_i == '0) == (hot_o == '0))
                else $error("edge presence disagrees with input");
        end
    end

endmodule

// File: rtl/onehot_enc.sv
module onehot_enc #(
    parameter int WIDTH = 24,
    parameter int IDX_W = 5
) (
    input  logic [WIDTH-1:0] hot_i,
    output logic [IDX_W-1:0] idx_o
);
    logic [IDX_W-1:0] idx_d;

    // Each index bit is the OR of all one-hot lines whose position has it set.
    always_comb begin
        idx_d = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (hot_i[i]) begin
                idx_d = idx_d | IDX_W'(i);
            end
        end
    end

    assign idx_o = idx_d;

    // R5: no index code at or above WIDTH, R3: zero index when nothing is hot
    always_comb begin
        if (!$isunknown(hot_i)) begin
            a_r5_idx_in_range: assert ({1'b0, idx_o} < (IDX_W+1)'(WIDTH))
                else $error("index %0d out of range", idx_o);
            a_r3_idle_zero: assert (hot_i != '0 || idx_o == '0)
                else $error("index nonzero with no winner");
        end
    end

endmodule

// File: rtl/prefix_prio_enc.sv
module prefix_prio_enc
    import prio_pkg::*;
#(
    parameter int WIDTH = 24,
    localparam int IDX_W = idx_width(WIDTH)
) (
    input  logic [WIDTH-1:0] req_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             valid_o
);
    logic [WIDTH-1:0] therm_q;
    logic [WIDTH-1:0] hot_q;

    prefix_or_net #(.WIDTH(WIDTH)) span_i (
        .req_i   (req_i),
        .therm_o (therm_q)
    );

    edge_pick #(.WIDTH(WIDTH)) edge_i (
        .therm_i (therm_q),
        .hot_o   (hot_q)
    );

    onehot_enc #(.WIDTH(WIDTH), .IDX_W(IDX_W)) enc_i (
        .hot_i (hot_q),
        .idx_o (idx_o)
    );

    // Any raised line has been spread into the top position.
    assign valid_o = therm_q[WIDTH-1];

    always_comb begin
        if (!$isunknown(req_i)) begin
            a_r2_valid_any: assert (valid_o == (|req_i))
                else $error("valid disagrees with request vector");
            a_r3_idle_index: assert (valid_o || idx_o == '0)
                else $error("index nonzero while idle");
            if (valid_o) begin
                a_r1_winner_set: assert (req_i[int'(idx_o)])
                    else $error("granted line %0d not requested", idx_o);
                for (int i = 0; i < WIDTH; i++) begin
                    if (i < int'(idx_o)) begin
                        a_r7_none_below: assert (!req_i[i])
                            else $error("line %0d outranks grant", i);
                    end
                end
            end
        end
    end

endmodule

// File: tb/prefix_prio_enc_tb_top.sv
module prefix_prio_enc_tb_top;
    localparam int W  = 24;
    localparam int IW = $clog2(W);

    typedef struct {
        logic [W-1:0]  req;
        logic [IW-1:0] idx;
        logic          valid;
        string         tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  req = '0;
    logic [IW-1:0] idx;
    logic          valid;
    item_t         sb_q[$];
    int            n_vec = 0;
    int            n_bad = 0;
    bit            done = 1'b0;

    always #5 clk = ~clk;

    prefix_prio_enc #(.WIDTH(W)) dut_i (
        .req_i   (req),
        .idx_o   (idx),
        .valid_o (valid)
    );

    // Reference: plain lowest-set-bit search.
    function automatic item_t model(input logic [W-1:0] r, input string t);
        item_t it;
        it.req = r; it.idx = '0; it.valid = 1'b0; it.tag = t;
        for (int i = W - 1; i >= 0; i--) begin
            if (r[i]) begin
                it.idx = IW'(i);
                it.valid = 1'b1;
            end
        end
        return it;
    endfunction

    // Driver: apply on falling edge, push expectation.
    task automatic drive(input logic [W-1:0] r, input string t);
        @(negedge clk);
        req = r;
        sb_q.push_back(model(r, t));
    endtask

    function automatic logic [W-1:0] rnd_vec();
        logic [W-1:0] v;
        v = W'($urandom);
        return v;
    endfunction

    // Monitor: on rising edge, half a period after the drive (R8).
    always @(posedge clk) begin
        if (rst_n && sb_q.size() > 0) begin
            item_t e;
            e = sb_q.pop_front();
            n_vec++;
            if (idx !== e.idx || valid !== e.valid || {1'b0, idx} >= (IW+1)'(W)) begin
                n_bad++;
                $display("FAIL %s req=%h idx act %0d exp %0d valid act %b exp %b",
                         e.tag, e.req, idx, e.idx, valid, e.valid);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R3 R2: idle vector first
        drive('0, "R3");
        // R4: only line 0
        drive(W'(1), "R4");
        // R6: only the top line, R5 upper code
        drive(W'(1) << (W - 1), "R6");
        // R1 R5: every single-bit vector
        for (int i = 0; i < W; i++) drive(W'(1) << i, "R1");
        // R2: all lines raised
        drive('1, "R2");
        // R7: fixed lowest bit k with random bits above, repeated per k
        for (int k = 0; k < W; k++) begin
            for (int n = 0; n < 20; n++) begin
                logic [W-1:0] v;
                v = (rnd_vec() | (W'(1) << k)) & ~((W'(1) << k) - W'(1));
                drive(v, "R7");
            end
        end
        // R1: sparse random vectors
        for (int n = 0; n < 300; n++) drive(rnd_vec() & rnd_vec() & rnd_vec(), "R1");
        // R2: dense random vectors
        for (int n = 0; n < 300; n++) drive(rnd_vec() | rnd_vec(), "R2");
        // R8: back-to-back changes each period, alternating idle and busy
        for (int n = 0; n < 40; n++) drive((n % 2 == 0) ? '0 : rnd_vec(), "R8");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog act timeout exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule